// File: doc/BRIEF.md
# Action List Sequencer

The block runs short programs of bus accesses against an accelerator's register space. Each program is a run of typed entries held in a local table: single register accesses, accesses that step across an address range, repeated accesses to one register that acts as a FIFO port, and a poll that reads one register until a masked field matches an expected value. An end marker closes each program. Write data comes either from a constant inside the entry or from a small parameter buffer. With the buffer, keys, buffer addresses and lengths can change without the table being edited.

A controller fills the table and the parameter buffer. It then pulses `start` with the index of the first entry of the wanted program. The sequencer issues the entries strictly in table order on a request/acknowledge master bus. Words returned by read entries are stored in a result buffer. When the program ends, the sequencer raises `done`, or `err` if a poll times out or an entry has an undefined kind.

Top module: `action_seq`

## Requirements
- R1: After reset `busy`, `done`, `err` and `bus_req` are low and `res_count` is zero.
- R2: A `start` pulse while idle begins execution at entry `start_idx`, sets `busy`, and clears `done`, `err` and `res_count`. A `start` while `busy` is ignored and the running program continues unchanged.
- R3: Entries are executed one at a time in ascending table order. A kind-0 (end) entry sets `done`, clears `busy` and issues no bus access. Entry layout: kind [2:0], write [3], param-source [4], size in bytes [7:5], count [15:8], byte offset [23:16], data/expected [55:24], mask [87:56].
- R4: A kind-1 (single) entry makes exactly one access at its offset. The count field is ignored, `bus_we` equals the write bit and `bus_size` equals the size field.
- R5: A kind-2 (range) entry makes `count` accesses, or one access if count is 0. Beat n uses address offset + n*size.
- R6: A kind-3 (FIFO) entry makes `count` accesses, or one if count is 0, and every beat uses the same address.
- R7: With the param-source bit clear, every write beat carries the data field. With the bit set, beat n carries parameter word (data + n), with the index wrapping at the buffer depth.
- R8: Each word read by a kind-1, kind-2 or kind-3 read entry is appended to the result buffer in arrival order. `res_data` returns word `res_addr`. Poll reads are not stored.
- R9: A kind-4 (poll) entry reads its offset until (rdata & mask) == (data & mask) and then moves on. If `count` reads all miss, with 0 treated as 1, the program stops with `err` set and `done` clear.
- R10: While `bus_req` is high without `bus_ack`, `bus_addr`, `bus_we` and `bus_wdata` stay stable until the cycle of the acknowledge.
- R11: An entry with kind 5, 6 or 7 stops the program with `err` set and no bus access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_we | input | 1 | Table write enable |
| tbl_addr | input | IW | Table entry index |
| tbl_wdata | input | EW | Entry word |
| prm_we | input | 1 | Parameter buffer write enable |
| prm_addr | input | PW | Parameter index |
| prm_wdata | input | DW | Parameter word |
| start | input | 1 | Run request |
| start_idx | input | IW | First entry of the program |
| busy | output | 1 | Program running |
| done | output | 1 | Last program ended normally |
| err | output | 1 | Last program stopped on error |
| bus_req | output | 1 | Access request |
| bus_we | output | 1 | Access is a write |
| bus_addr | output | AW | Byte address |
| bus_size | output | 3 | Access size in bytes |
| bus_wdata | output | DW | Write data |
| bus_ack | input | 1 | Access accepted this cycle |
| bus_rdata | input | DW | Read data, valid with ack |
| res_addr | input | RW | Result buffer read index |
| res_data | output | DW | Result word |
| res_count | output | RW+1 | Words stored in the result buffer |

## Verification
One program mixes every access kind. Its write entries take data from constants and from the parameter buffer, and the bus log tells stepped addresses from held ones and parameter data from constant data. The bus slave withholds its acknowledge on every third cycle, which separates a beat that waits for its acknowledge from one that advances early. A poll that matches on its third read is compared with a poll whose masked bit never sets: the first must continue the program and the second must raise the error after exactly its limit of reads. A second start during a run, an undefined kind, and range entries with a 2-byte size and a zero count test the start guard, the error path and the beat count.

// File: rtl/action_seq.sv
module action_seq #(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter int DEPTH = 16,
  parameter int PDEPTH = 8,
  parameter int RDEPTH = 16,
  localparam int IW = $clog2(DEPTH),
  localparam int PW = $clog2(PDEPTH),
  localparam int RW = $clog2(RDEPTH),
  localparam int EW = 2*DW + AW + 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tbl_we,
  input  logic [IW-1:0] tbl_addr,
  input  logic [EW-1:0] tbl_wdata,
  input  logic          prm_we,
  input  logic [PW-1:0] prm_addr,
  input  logic [DW-1:0] prm_wdata,
  input  logic          start,
  input  logic [IW-1:0] start_idx,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [2:0]    bus_size,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_ack,
  input  logic [DW-1:0] bus_rdata,
  input  logic [RW-1:0] res_addr,
  output logic [DW-1:0] res_data,
  output logic [RW:0]   res_count
);
  localparam logic [2:0] K_END = 3'd0, K_ONE = 3'd1, K_RANGE = 3'd2, K_FIFO = 3'd3, K_POLL = 3'd4;

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_EXEC, S_BUS} state_t;
  state_t state;

  logic [EW-1:0] tbl [DEPTH];
  logic [DW-1:0] prm [PDEPTH];
  logic [DW-1:0] res [RDEPTH];
  logic [EW-1:0] ent;
  logic [IW-1:0] pc;
  logic [7:0]    beat;

  wire [2:0]    kind = ent[2:0];
  wire          wr   = ent[3];
  wire          src  = ent[4];
  wire [2:0]    size = ent[7:5];
  wire [7:0]    cnt  = ent[15:8];
  wire [AW-1:0] offs = ent[16 +: AW];
  wire [DW-1:0] dat  = ent[16+AW +: DW];
  wire [DW-1:0] msk  = ent[16+AW+DW +: DW];

  wire [7:0]    last  = (kind == K_ONE || cnt == 8'd0) ? 8'd0 : cnt - 8'd1;
  wire [AW-1:0] step  = AW'(beat) * AW'(size);
  wire          match = ((bus_rdata ^ dat) & msk) == '0;
  wire          ack   = (state == S_BUS) && bus_ack;
  wire          push  = ack && !wr && kind != K_POLL;
  wire [PW-1:0] pidx  = PW'(dat) + PW'(beat);

  assign bus_req   = state == S_BUS;
  assign bus_we    = wr && kind != K_POLL;
  assign bus_size  = size;
  assign bus_addr  = offs + ((kind == K_RANGE) ? step : '0);
  assign bus_wdata = src ? prm[pidx] : dat;
  assign res_data  = res[res_addr];

  always_ff @(posedge clk) begin
    if (tbl_we) tbl[tbl_addr] <= tbl_wdata;
    if (prm_we) prm[prm_addr] <= prm_wdata;
    if (push && res_count < (RW+1)'(RDEPTH)) res[res_count[RW-1:0]] <= bus_rdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      busy <= 1'b0;
      done <= 1'b0;
      err <= 1'b0;
      pc <= '0;
      beat <= '0;
      ent <= '0;
      res_count <= '0;
    end else begin
      if (push && res_count < (RW+1)'(RDEPTH)) res_count <= res_count + 1'b1;
      case (state)
        S_IDLE: if (start) begin
          pc <= start_idx;
          busy <= 1'b1;
          done <= 1'b0;
          err <= 1'b0;
          res_count <= '0;
          state <= S_LOAD;
        end
        S_LOAD: begin
          ent <= tbl[pc];
          beat <= '0;
          state <= S_EXEC;
        end
        S_EXEC: begin
          if (kind == K_END) begin
            done <= 1'b1;
            busy <= 1'b0;
            state <= S_IDLE;
          end else if (kind > K_POLL) begin
            err <= 1'b1;
            busy <= 1'b0;
            state <= S_IDLE;
          end else begin
            state <= S_BUS;
          end
        end
        S_BUS: if (bus_ack) begin
          if (kind == K_POLL) begin
            if (match) begin
              pc <= pc + 1'b1;
              state <= S_LOAD;
            end else if ({1'b0, beat} + 9'd1 >= {1'b0, cnt}) begin
              err <= 1'b1;
              busy <= 1'b0;
              state <= S_IDLE;
            end else begin
              beat <= beat + 1'b1;
            end
          end else if (beat == last) begin
            pc <= pc + 1'b1;
            state <= S_LOAD;
          end else begin
            beat <= beat + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/action_seq_chk.sv
module action_seq_chk #(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter int RW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          err,
  input logic          bus_req,
  input logic          bus_ack,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic [RW:0]   res_count
);
  // R3
  req_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n) bus_req |-> busy);
  // R9
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n) !(done && err));
  // R10
  held_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));
  // R2
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy && !done && !err && res_count == '0);
  // R8
  res_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> res_count >= $past(res_count));
endmodule

bind action_seq action_seq_chk #(.AW(AW), .DW(DW), .RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .err(err),
  .bus_req(bus_req), .bus_ack(bus_ack), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .res_count(res_count)
);

// File: tb/sim_action_seq.sv
`timescale 1ns/1ps
module sim_action_seq;
  localparam int AW = 8, DW = 32, IW = 4, PW = 3, RW = 4, EW = 2*DW + AW + 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tbl_we = 1'b0, prm_we = 1'b0, start = 1'b0;
  logic [IW-1:0] tbl_addr = '0, start_idx = '0;
  logic [EW-1:0] tbl_wdata = '0;
  logic [PW-1:0] prm_addr = '0;
  logic [DW-1:0] prm_wdata = '0;
  logic [RW-1:0] res_addr = '0;
  logic busy, done, err, bus_req, bus_we, bus_ack;
  logic [AW-1:0] bus_addr;
  logic [2:0] bus_size;
  logic [DW-1:0] bus_wdata, bus_rdata, res_data;
  logic [RW:0] res_count;

  always #2.5 clk = ~clk;

  action_seq u0 (.*);

  int cyc = 0, tests = 0, fails = 0;
  logic [DW-1:0] regs [64];
  logic [DW-1:0] poll_cnt;
  logic [40:0] log_e [64];
  logic [2:0]  log_sz [64];
  int log_n = 0;

  assign bus_ack   = bus_req && (cyc % 3 != 0);
  assign bus_rdata = (bus_addr == 8'hF0) ? poll_cnt + 1 : regs[bus_addr[7:2]];

  always_ff @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      poll_cnt <= '0;
      for (int i = 0; i < 64; i++) regs[i] <= 32'h1000 + i;
    end else if (bus_req && bus_ack) begin
      if (bus_we) regs[bus_addr[7:2]] <= bus_wdata;
      if (!bus_we && bus_addr == 8'hF0) poll_cnt <= poll_cnt + 1;
      if (log_n < 64) begin
        log_e[log_n] <= {bus_we, bus_addr, bus_we ? bus_wdata : bus_rdata};
        log_sz[log_n] <= bus_size;
      end
      log_n <= log_n + 1;
    end
  end

  // R10 monitor
  logic pend = 1'b0;
  logic [AW-1:0] p_addr;
  logic [DW-1:0] p_data;
  logic p_we;
  int stall_seen = 0, stall_bad = 0;
  always @(negedge clk) begin
    if (pend) begin
      stall_seen++;
      if (!bus_req || bus_addr != p_addr || bus_wdata != p_data || bus_we != p_we) stall_bad++;
    end
    pend = bus_req && !bus_ack;
    p_addr = bus_addr; p_data = bus_wdata; p_we = bus_we;
  end

  always @(posedge clk) if (cyc > 100000) begin
    $display("FAIL watchdog: actual cycles %0d expected < 100000", cyc);
    fails++;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  localparam logic [40:0] EXP1 [14] = '{
    {1'b1, 8'h04, 32'hA5A50001},
    {1'b1, 8'h24, 32'hC0DE0002}, {1'b1, 8'h28, 32'hC0DE0003},
    {1'b1, 8'h2C, 32'hC0DE0004}, {1'b1, 8'h30, 32'hC0DE0005},
    {1'b1, 8'h40, 32'h00000077}, {1'b1, 8'h40, 32'h00000077}, {1'b1, 8'h40, 32'h00000077},
    {1'b0, 8'h04, 32'hA5A50001}, {1'b0, 8'h08, 32'h00001002},
    {1'b0, 8'hF0, 32'h1}, {1'b0, 8'hF0, 32'h2}, {1'b0, 8'hF0, 32'h3},
    {1'b0, 8'h28, 32'hC0DE0003}
  };

  task automatic chk(input string tag, input logic ok, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [EW-1:0] mk(input logic [2:0] k, input logic w, input logic s,
      input logic [2:0] sz, input logic [7:0] c, input logic [7:0] o, input logic [31:0] d, input logic [31:0] m);
    return {m, d, o, c, sz, s, w, k};
  endfunction

  task automatic put(input int idx, input logic [EW-1:0] e);
    @(negedge clk); tbl_we = 1'b1; tbl_addr = IW'(idx); tbl_wdata = e;
    @(negedge clk); tbl_we = 1'b0;
  endtask

  task automatic go(input int idx);
    @(negedge clk); start = 1'b1; start_idx = IW'(idx);
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
  endtask

  initial begin
    int base;
    repeat (3) @(negedge clk);
    chk("R1 flags", !busy && !done && !err && !bus_req, {busy, done, err, bus_req}, 0);
    chk("R1 res_count", res_count == 0, res_count, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); prm_we = 1'b1; prm_addr = PW'(i); prm_wdata = 32'hC0DE0000 + i;
    end
    @(negedge clk); prm_we = 1'b0;

    put(0, mk(3'd1, 1, 0, 3'd4, 8'd9, 8'h04, 32'hA5A50001, 0));
    put(1, mk(3'd2, 1, 1, 3'd4, 8'd4, 8'h24, 32'd2, 0));
    put(2, mk(3'd3, 1, 0, 3'd4, 8'd3, 8'h40, 32'h77, 0));
    put(3, mk(3'd2, 0, 0, 3'd4, 8'd2, 8'h04, 0, 0));
    put(4, mk(3'd4, 1, 0, 3'd4, 8'd10, 8'hF0, 32'h3, 32'hFF));
    put(5, mk(3'd1, 0, 0, 3'd4, 8'd0, 8'h28, 0, 0));
    put(6, mk(3'd0, 0, 0, 3'd0, 8'd0, 8'h00, 0, 0));
    put(8, mk(3'd4, 0, 0, 3'd4, 8'd4, 8'hF0, 32'h100, 32'h100));
    put(9, mk(3'd0, 0, 0, 3'd0, 8'd0, 8'h00, 0, 0));
    put(10, mk(3'd6, 1, 0, 3'd4, 8'd1, 8'h10, 0, 0));
    put(11, mk(3'd2, 1, 0, 3'd2, 8'd0, 8'h50, 32'h9, 0));
    put(12, mk(3'd2, 1, 0, 3'd2, 8'd3, 8'h60, 32'h5, 0));
    put(13, mk(3'd0, 0, 0, 3'd0, 8'd0, 8'h00, 0, 0));

    // program 1: all kinds
    go(0);
    chk("R2 busy after start", busy, busy, 1);
    wait_idle();
    chk("R3 done", done && !err && !busy, {done, err, busy}, 3'b100);
    chk("R3 access count", log_n == 14, log_n, 14);
    for (int i = 0; i < 14; i++)
      chk($sformatf("R4 R5 R6 R7 R9 log %0d", i), log_e[i] == EXP1[i], log_e[i], EXP1[i]);
    chk("R4 size", log_sz[0] == 3'd4, log_sz[0], 4);
    chk("R8 count", res_count == 3, res_count, 3);
    begin
      logic [DW-1:0] er [3] = '{32'hA5A50001, 32'h1002, 32'hC0DE0003};
      for (int i = 0; i < 3; i++) begin
        @(negedge clk); res_addr = RW'(i); #1;
        chk($sformatf("R8 word %0d", i), res_data == er[i], res_data, er[i]);
      end
    end

    // program 2: poll timeout, second start ignored
    base = log_n;
    go(8);
    chk("R2 results cleared", res_count == 0, res_count, 0);
    @(negedge clk); start = 1'b1; start_idx = 0;
    @(negedge clk); start = 1'b0;
    wait_idle();
    chk("R9 timeout err", err && !done, {err, done}, 2'b10);
    chk("R9 poll reads", log_n - base == 4, log_n - base, 4);
    chk("R2 restart ignored", log_e[base + 3][39:32] == 8'hF0 && log_n - base == 4, log_e[base + 3][39:32], 8'hF0);
    chk("R8 poll not stored", res_count == 0, res_count, 0);

    // undefined kind
    base = log_n;
    go(10);
    wait_idle();
    chk("R11 err", err && !done, {err, done}, 2'b10);
    chk("R11 no access", log_n == base, log_n - base, 0);

    // range with 2-byte size, zero count
    base = log_n;
    go(11);
    wait_idle();
    chk("R5 done", done, done, 1);
    chk("R5 beats", log_n - base == 4, log_n - base, 4);
    chk("R5 zero count", log_e[base][39:32] == 8'h50, log_e[base][39:32], 8'h50);
    chk("R5 step 1", log_e[base + 2][39:32] == 8'h62, log_e[base + 2][39:32], 8'h62);
    chk("R5 step 2", log_e[base + 3][39:32] == 8'h64, log_e[base + 3][39:32], 8'h64);
    chk("R7 const data", log_e[base + 3][31:0] == 32'h5, log_e[base + 3][31:0], 5);
    chk("R4 size 2", log_sz[base + 1] == 3'd2, log_sz[base + 1], 2);

    chk("R10 held request", stall_seen > 0 && stall_bad == 0, stall_bad, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule